// File: doc/BRIEF.md
# Processor Interrupt Aggregation Controller

This block gathers interrupt requests from on-chip peripherals, from direct data-movement channels and from external pins, and presents them to one processor core as a maskable IRQ line, a maskable FIQ line and a separate non-maskable line. Each peripheral drives several raw sources. These are gated by per-source enables and then ORed into one request. The data-movement channels stay as separate requests, one per channel, and are never merged. Sixteen active-low external pins and one active-low high-priority pin pass through two-flop synchronisers and join the same request set.

Every request has its own mask bit and a steering bit. The steering bit sends the request to IRQ or to FIQ. For each line a fixed priority encoder picks the active request with the lowest index. The handler vector is a programmable base plus four times that index. When no request is active on a line, the vector reads as the reserved code 0x0000_0001. A falling edge on the synchronised NMI pin sets a sticky flag that drives the non-maskable output and is cleared by a register write. Four active-low PCI-style lines can each be mapped to one request, and they are driven only while the device acts as an endpoint.

Top module: `intr_aggregator`

## Requirements
- R1: After reset, irq_o, fiq_o and nmi_o are 0, pci_int_no is 4'hF, every register reads 0, and both vector registers read 0x0000_0001.
- R2: An external pin ext_irq_ni[j] held low is request index 9+j. It raises IRQ within 4 cycles and drops it again within 4 cycles after the pin goes high.
- R3: Peripheral p merges periph_src_i[4p+3:4p] under the matching bits of the sub-enable register (address 0). A sub-source whose enable bit is 0 has no effect. The merged request is index 5+p.
- R4: Data-movement input dma_src_i[k] is its own request, index 1+k. Requests from several channels show as separate bits of the pending register (address 3).
- R5: A request whose bit in the mask register (address 1) is 0 appears neither in the pending register nor on IRQ or FIQ.
- R6: Steering register bit i (address 2) set to 1 routes request i to FIQ; cleared, it routes request i to IRQ. A request never drives both lines.
- R7: Among the active requests on a line, the lowest index wins. The vector (IRQ at address 5, FIQ at address 6) is the base (address 4, bits 1:0 forced to 0) plus 4 times the winning index.
- R8: A line with no active request reads the vector code 0x0000_0001.
- R9: A falling edge on nmi_ni sets nmi_o, whatever the mask and steering. Writing 1 to bit 0 of address 7 clears it. Holding the pin low does not set it again. Address 7 bit 0 reads the flag.
- R10: PCI lane l uses bits 8l+7 (enable) and 8l+4..8l (request index) of address 8. pci_int_no[l] is low only while endpoint_i is 1, the lane is enabled and that request is pending.
- R11: The high-priority pin hp_irq_ni is request index 0 and outranks every other request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_irq_ni | input | 16 | External interrupt pins, active low |
| hp_irq_ni | input | 1 | High-priority external pin, active low |
| nmi_ni | input | 1 | Non-maskable pin, falling-edge triggered |
| periph_src_i | input | 16 | Raw peripheral sources, 4 per peripheral |
| dma_src_i | input | 4 | Data-movement channel requests |
| endpoint_i | input | 1 | Device operates as a PCI endpoint |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| irq_o | output | 1 | Maskable normal interrupt to core |
| fiq_o | output | 1 | Maskable fast interrupt to core |
| nmi_o | output | 1 | Non-maskable interrupt to core |
| pci_int_no | output | 4 | PCI-style interrupt lines, active low |

## Verification
The bench drives two requests on one line at the same time, once on IRQ and once on FIQ, and once with both steered to FIQ. A design with a reversed priority or a steering bit that leaks would report the wrong vector or keep IRQ asserted. It enables a peripheral's sub-sources one at a time, so that a design that merges before gating would raise IRQ for a disabled sub-source. It clears the NMI flag while the pin is still held low, and then makes a second edge; a level-sensitive or non-sticky design would set the flag again or drop it early. The PCI lanes are checked with endpoint mode off and on, and with a lane whose index is set but whose enable bit is not.

// File: rtl/iac_pkg.sv
package iac_pkg;
  typedef enum logic [3:0] {
    A_SUB_EN  = 4'd0,
    A_MASK    = 4'd1,
    A_STEER   = 4'd2,
    A_PEND    = 4'd3,
    A_VBASE   = 4'd4,
    A_IRQ_VEC = 4'd5,
    A_FIQ_VEC = 4'd6,
    A_NMI     = 4'd7,
    A_PCI_MAP = 4'd8
  } reg_addr_e;

  localparam int unsigned DW       = 32;
  localparam int unsigned PCI_N    = 4;
  localparam int unsigned LANE_W   = 8;
  localparam logic [DW-1:0] NONE_VEC = 32'h0000_0001;
endpackage

// File: rtl/iac_sync.sv
module iac_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/iac_merge.sv
module iac_merge #(
  parameter int unsigned N_PERIPH = 4,
  parameter int unsigned SRC_PER  = 4,
  localparam int unsigned SUB_N   = N_PERIPH * SRC_PER
) (
  input  logic [SUB_N-1:0]    src_i,
  input  logic [SUB_N-1:0]    en_i,
  output logic [N_PERIPH-1:0] req_o
);
  for (genvar p = 0; p < N_PERIPH; p++) begin : g_periph
    assign req_o[p] = |(src_i[p*SRC_PER +: SRC_PER] & en_i[p*SRC_PER +: SRC_PER]);
  end
endmodule

// File: rtl/iac_prio.sv
module iac_prio #(
  parameter int unsigned N = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign found_o = |req_i;
endmodule

// File: rtl/intr_aggregator.sv
module intr_aggregator #(
  parameter int unsigned N_EXT    = 16,
  parameter int unsigned N_DMA    = 4,
  parameter int unsigned N_PERIPH = 4,
  parameter int unsigned SRC_PER  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_EXT-1:0]          ext_irq_ni,
  input  logic                      hp_irq_ni,
  input  logic                      nmi_ni,
  input  logic [N_PERIPH*SRC_PER-1:0] periph_src_i,
  input  logic [N_DMA-1:0]          dma_src_i,
  input  logic                      endpoint_i,
  input  logic                      reg_we_i,
  input  logic [3:0]                reg_addr_i,
  input  logic [31:0]               reg_wdata_i,
  output logic [31:0]               reg_rdata_o,
  output logic                      irq_o,
  output logic                      fiq_o,
  output logic                      nmi_o,
  output logic [3:0]                pci_int_no
);
  import iac_pkg::*;

  localparam int unsigned SUB_N   = N_PERIPH * SRC_PER;
  localparam int unsigned N_SRC   = 1 + N_DMA + N_PERIPH + N_EXT;
  localparam int unsigned IDX_W   = $clog2(N_SRC);
  localparam int unsigned SYNC_W  = N_EXT + 2;
  localparam int unsigned SEL_W   = 5;

  // ---------------- pin synchronisers ----------------
  logic [SYNC_W-1:0] pin_s;
  logic [N_EXT-1:0]  ext_s_n;
  logic              hp_s_n, nmi_s_n;

  iac_sync #(.W(SYNC_W), .RST_VAL({SYNC_W{1'b1}})) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({nmi_ni, hp_irq_ni, ext_irq_ni}),
    .q_o   (pin_s)
  );

  assign ext_s_n = pin_s[N_EXT-1:0];
  assign hp_s_n  = pin_s[N_EXT];
  assign nmi_s_n = pin_s[N_EXT+1];

  // ---------------- configuration registers ----------------
  logic [SUB_N-1:0]      sub_en_q;
  logic [N_SRC-1:0]      src_en_q;
  logic [N_SRC-1:0]      steer_q;
  logic [DW-1:0]         vbase_q;
  logic [PCI_N*LANE_W-1:0] pci_map_q;
  logic                  nmi_q, nmi_prev_q;
  logic                  nmi_fall, nmi_clr;

  assign nmi_fall = nmi_prev_q & ~nmi_s_n;
  assign nmi_clr  = reg_we_i && (reg_addr_i == A_NMI) && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_en_q  <= '0;
      src_en_q  <= '0;
      steer_q   <= '0;
      vbase_q   <= '0;
      pci_map_q <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        A_SUB_EN:  sub_en_q  <= reg_wdata_i[SUB_N-1:0];
        A_MASK:    src_en_q  <= reg_wdata_i[N_SRC-1:0];
        A_STEER:   steer_q   <= reg_wdata_i[N_SRC-1:0];
        A_VBASE:   vbase_q   <= {reg_wdata_i[DW-1:2], 2'b00};
        A_PCI_MAP: pci_map_q <= reg_wdata_i[PCI_N*LANE_W-1:0];
        default: ;
      endcase
    end
  end

  // sticky NMI flag, a new edge wins over a clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_prev_q <= 1'b1;
      nmi_q      <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_s_n;
      if (nmi_fall)     nmi_q <= 1'b1;
      else if (nmi_clr) nmi_q <= 1'b0;
    end
  end

  // ---------------- request collection ----------------
  logic [N_PERIPH-1:0] periph_req;
  logic [N_SRC-1:0]    raw_req;
  logic [N_SRC-1:0]    pend_q;

  iac_merge #(.N_PERIPH(N_PERIPH), .SRC_PER(SRC_PER)) i_merge (
    .src_i(periph_src_i),
    .en_i (sub_en_q),
    .req_o(periph_req)
  );

  // index order: hp, dma, peripherals, external pins
  assign raw_req = {~ext_s_n, periph_req, dma_src_i, ~hp_s_n};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= raw_req & src_en_q;
  end

  // ---------------- per-line selection ----------------
  logic [1:0]           line_found;
  logic [1:0][IDX_W-1:0] line_idx;
  logic [1:0][DW-1:0]    line_vec;
  logic [1:0][N_SRC-1:0] line_req;

  assign line_req[0] = pend_q & ~steer_q;  // IRQ
  assign line_req[1] = pend_q &  steer_q;  // FIQ

  for (genvar g = 0; g < 2; g++) begin : g_line
    iac_prio #(.N(N_SRC)) i_prio (
      .req_i  (line_req[g]),
      .found_o(line_found[g]),
      .idx_o  (line_idx[g])
    );
    assign line_vec[g] = line_found[g] ? vbase_q + DW'({line_idx[g], 2'b00}) : NONE_VEC;
  end

  logic [DW-1:0] irq_vec, fiq_vec;
  assign irq_vec = line_vec[0];
  assign fiq_vec = line_vec[1];
  assign irq_o   = line_found[0];
  assign fiq_o   = line_found[1];
  assign nmi_o   = nmi_q;

  // ---------------- PCI-style lines ----------------
  logic [31:0] pend_w;
  assign pend_w = 32'(pend_q);

  for (genvar l = 0; l < PCI_N; l++) begin : g_pci
    logic [SEL_W-1:0] sel;
    logic             lane_en;
    assign sel     = pci_map_q[l*LANE_W +: SEL_W];
    assign lane_en = pci_map_q[l*LANE_W + LANE_W - 1];
    assign pci_int_no[l] = ~(endpoint_i & lane_en & pend_w[sel]);
  end

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_SUB_EN:  reg_rdata_o = 32'(sub_en_q);
      A_MASK:    reg_rdata_o = 32'(src_en_q);
      A_STEER:   reg_rdata_o = 32'(steer_q);
      A_PEND:    reg_rdata_o = 32'(pend_q);
      A_VBASE:   reg_rdata_o = vbase_q;
      A_IRQ_VEC: reg_rdata_o = irq_vec;
      A_FIQ_VEC: reg_rdata_o = fiq_vec;
      A_NMI:     reg_rdata_o = {31'd0, nmi_q};
      A_PCI_MAP: reg_rdata_o = 32'(pci_map_q);
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/intr_aggregator_chk.sv
module intr_aggregator_chk #(
  parameter int unsigned N_SRC = 25
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             fiq_o,
  input logic             nmi_o,
  input logic [3:0]       pci_int_no,
  input logic             endpoint_i,
  input logic [31:0]      irq_vec,
  input logic [31:0]      fiq_vec,
  input logic [N_SRC-1:0] src_en_q,
  input logic [N_SRC-1:0] steer_q,
  input logic             reg_we_i,
  input logic [3:0]       reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic             nmi_fall
);
  a_r8_irq_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> irq_vec == 32'h0000_0001);

  a_r8_fiq_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fiq_o |-> fiq_vec == 32'h0000_0001);

  a_r7_vec_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_vec[1:0] == 2'b00);

  a_r5_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(src_en_q) == '0) |-> (!irq_o && !fiq_o));

  a_r6_all_fiq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steer_q == '1) |-> !irq_o);

  a_r10_pci_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !endpoint_i |-> pci_int_no == 4'hF);

  a_r9_nmi_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_fall |=> nmi_o);

  a_r9_nmi_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_o && !(reg_we_i && reg_addr_i == 4'd7 && reg_wdata_i[0])) |=> nmi_o);
endmodule

bind intr_aggregator intr_aggregator_chk #(.N_SRC(N_SRC)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_o      (irq_o),
  .fiq_o      (fiq_o),
  .nmi_o      (nmi_o),
  .pci_int_no (pci_int_no),
  .endpoint_i (endpoint_i),
  .irq_vec    (irq_vec),
  .fiq_vec    (fiq_vec),
  .src_en_q   (src_en_q),
  .steer_q    (steer_q),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .nmi_fall   (nmi_fall)
);

// File: tb/test_intr_aggregator.sv
`timescale 1ns/1ps
module test_intr_aggregator;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] ext_irq_ni = 16'hFFFF;
  logic        hp_irq_ni = 1'b1;
  logic        nmi_ni = 1'b1;
  logic [15:0] periph_src_i = '0;
  logic [3:0]  dma_src_i = '0;
  logic        endpoint_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, fiq_o, nmi_o;
  logic [3:0]  pci_int_no;

  intr_aggregator i_intr_aggregator (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_irq_ni(ext_irq_ni), .hp_irq_ni(hp_irq_ni),
    .nmi_ni(nmi_ni), .periph_src_i(periph_src_i), .dma_src_i(dma_src_i),
    .endpoint_i(endpoint_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o),
    .fiq_o(fiq_o), .nmi_o(nmi_o), .pci_int_no(pci_int_no)
  );

  always #4 clk_i = ~clk_i;

  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] NONE = 32'h0000_0001;
  localparam logic [31:0] ALL  = 32'h01FF_FFFF;

  typedef struct {
    string       tag;
    bit          is_port;
    logic [31:0] exp;
  } item_t;

  item_t sb_q[$];
  item_t it;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // monitor: compares queued expectations
  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      logic [31:0] act;
      it = sb_q.pop_front();
      act = it.is_port ? {25'd0, pci_int_no, nmi_o, fiq_o, irq_o} : reg_rdata_o;
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [31:0] vec(int idx);
    return BASE + 32'(idx * 4);
  endfunction

  function automatic logic [31:0] ports(bit irq, bit fiq, bit nmi, logic [3:0] pci);
    return {25'd0, pci, nmi, fiq, irq};
  endfunction

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk_i); #1;
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk_i);
    #1;
  endtask

  task automatic chk_reg(string tag, logic [3:0] a, logic [31:0] e);
    item_t x;
    @(posedge clk_i); #1;
    reg_addr_i = a;
    x.tag = tag; x.is_port = 1'b0; x.exp = e;
    sb_q.push_back(x);
    @(negedge clk_i); #1;
  endtask

  task automatic chk_port(string tag, logic [31:0] e);
    item_t x;
    @(posedge clk_i); #1;
    x.tag = tag; x.is_port = 1'b1; x.exp = e;
    sb_q.push_back(x);
    @(negedge clk_i); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    settle();

    // R1 reset state
    chk_port("R1 ports", ports(0, 0, 0, 4'hF));
    chk_reg("R1 pend", 4'd3, 32'd0);
    chk_reg("R1 sub_en", 4'd0, 32'd0);
    chk_reg("R1 irq vec", 4'd5, NONE);
    chk_reg("R1 fiq vec", 4'd6, NONE);

    wr(4'd1, ALL);
    wr(4'd4, BASE | 32'h3);
    chk_reg("R7 base low bits", 4'd4, BASE);

    // R2 external pin level
    ext_irq_ni[3] = 1'b0;
    settle();
    chk_port("R2 irq on", ports(1, 0, 0, 4'hF));
    chk_reg("R2 pend bit 12", 4'd3, 32'h0000_1000);
    chk_reg("R7 irq vec idx 12", 4'd5, vec(12));
    chk_reg("R8 fiq none", 4'd6, NONE);
    ext_irq_ni[3] = 1'b1;
    settle();
    chk_port("R2 irq off", ports(0, 0, 0, 4'hF));
    chk_reg("R8 irq none", 4'd5, NONE);

    // R3 peripheral merge with sub-enables
    periph_src_i[6] = 1'b1;
    settle();
    chk_port("R3 disabled sub ignored", ports(0, 0, 0, 4'hF));
    chk_reg("R3 pend empty", 4'd3, 32'd0);
    wr(4'd0, 32'h0000_0040);
    periph_src_i[5] = 1'b1;
    settle();
    chk_reg("R3 merged idx 6", 4'd5, vec(6));
    chk_reg("R3 pend bit 6", 4'd3, 32'h0000_0040);
    periph_src_i[6] = 1'b0;
    settle();
    chk_port("R3 only disabled left", ports(0, 0, 0, 4'hF));
    periph_src_i = '0;

    // R4 direct channels unmerged
    dma_src_i = 4'b0101;
    settle();
    chk_reg("R4 pend bits 1 3", 4'd3, 32'h0000_000A);
    chk_reg("R4 irq vec idx 1", 4'd5, vec(1));

    // R5 mask
    wr(4'd1, ALL & ~32'h2);
    settle();
    chk_reg("R5 masked pend", 4'd3, 32'h0000_0008);
    chk_reg("R5 masked vec", 4'd5, vec(3));
    wr(4'd1, ALL);
    dma_src_i = '0;

    // R6 / R7 steering and priority
    ext_irq_ni[0] = 1'b0;
    ext_irq_ni[5] = 1'b0;
    wr(4'd2, 32'h0000_4000);
    settle();
    chk_port("R6 both lines", ports(1, 1, 0, 4'hF));
    chk_reg("R6 irq vec idx 9", 4'd5, vec(9));
    chk_reg("R6 fiq vec idx 14", 4'd6, vec(14));
    wr(4'd2, 32'h0000_4200);
    settle();
    chk_port("R6 irq released", ports(0, 1, 0, 4'hF));
    chk_reg("R8 irq none after steer", 4'd5, NONE);
    chk_reg("R7 fiq lowest wins", 4'd6, vec(9));
    ext_irq_ni = 16'hFFFF;
    wr(4'd2, 32'd0);

    // R11 high-priority pin
    hp_irq_ni = 1'b0;
    ext_irq_ni[15] = 1'b0;
    settle();
    chk_reg("R11 pend", 4'd3, 32'h0100_0001);
    chk_reg("R11 vec idx 0", 4'd5, vec(0));
    hp_irq_ni = 1'b1;
    ext_irq_ni[15] = 1'b1;

    // R9 NMI independent of masks
    wr(4'd1, 32'd0);
    nmi_ni = 1'b0;
    settle();
    chk_port("R9 nmi set", ports(0, 0, 1, 4'hF));
    chk_reg("R9 nmi reg", 4'd7, 32'd1);
    wr(4'd7, 32'd1);
    settle();
    chk_reg("R9 cleared while low", 4'd7, 32'd0);
    chk_port("R9 no retrigger", ports(0, 0, 0, 4'hF));
    nmi_ni = 1'b1;
    settle();
    nmi_ni = 1'b0;
    settle();
    chk_port("R9 second edge", ports(0, 0, 1, 4'hF));
    wr(4'd7, 32'd1);
    nmi_ni = 1'b1;
    settle();
    chk_port("R9 final clear", ports(0, 0, 0, 4'hF));

    // R10 PCI lanes
    wr(4'd1, ALL);
    wr(4'd8, 32'h008C_000C);
    ext_irq_ni[3] = 1'b0;
    settle();
    chk_port("R10 not endpoint", ports(1, 0, 0, 4'hF));
    endpoint_i = 1'b1;
    settle();
    chk_port("R10 lane 2 only", ports(1, 0, 0, 4'b1011));
    ext_irq_ni[3] = 1'b1;
    settle();
    chk_port("R10 lane released", ports(0, 0, 0, 4'hF));

    repeat (2) @(posedge clk_i);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule